// File: doc/BRIEF.md
# Interval Timer with Pulse Counting

A 16-bit down-counter that a CPU programs over a small byte-wide register bus. The counter has two modes. In free-running mode it counts one step per clock and reloads itself from a 16-bit latch. The reload and the timeout event come one clock after the counter has stepped past zero to all ones, so one period is the latch value plus two cycles. In pulse-counting mode it counts one step per falling edge of an external input. That input is resynchronised to the clock first. The timeout event in this mode fires once, when the count reaches zero.

A timeout always sets a sticky timer flag, whether or not the interrupt is enabled. A separate enable bit decides whether that flag pulls the active-low interrupt output down. Software can clear the flag in three ways: by writing a mask with a one in the flag's bit, by reading the low counter byte, or by restarting the counter.

Register map (`addr`):

| addr | Access | Contents |
|------|--------|----------|
| 0 | read | Counter low byte; the read clears the flag |
| 0 | write | Latch low byte |
| 1 | read | Counter high byte |
| 1 | write | Latch high byte and restart: the counter is loaded with {wdata, latch low}, counting starts and the flag is cleared |
| 2 | read/write | Latch low byte, with no effect on the counter |
| 3 | read/write | Latch high byte, with no effect on the counter |
| 4 | read/write | Mode, in bit 0: 0 is free-running, 1 is pulse counting |
| 5 | read | Flag, in bit 6 |
| 5 | write | Clear mask: a one in bit 6 clears the flag, zeros leave it unchanged |
| 6 | read/write | Interrupt enable, in bit 6 |

`rdata` is combinational from `addr`. The clearing side effect of address 0 happens only when `cs` is high and `we` is low.

Top module: `pulse_timer16`

## Requirements
- R1: After reset the counter reads 0, the flag (address 5, bit 6) reads 0 and `irq_n` is high.
- R2: In free-running mode (address 4, bit 0 = 0), after a restart write of value L the first flag set comes L+2 clock edges after the write edge. Each later set comes L+2 edges after the previous one.
- R3: In free-running mode the counter reads L-n n edges after the restart write, for n from 0 to L. It reads 0xFFFF at n = L+1 and L again at n = L+2.
- R4: In pulse-counting mode (address 4, bit 0 = 1) the counter steps down by one on each falling edge of `cnt_pin`. Rising edges leave it unchanged.
- R5: In pulse-counting mode the flag is set when the count steps from 1 to 0. It is not set again by further edges until the next restart write.
- R6: The flag is set on timeout even when the enable (address 6, bit 6) is 0, and `irq_n` then stays high.
- R7: A write to address 5 with bit 6 = 1 clears the flag. A write with bit 6 = 0 leaves it set.
- R8: A read access of address 0 clears the flag.
- R9: A write to address 1 clears the flag and reloads the counter with {wdata, latch low byte}.
- R10: `irq_n` is low exactly while the flag and the enable are both 1.
- R11: Writes to addresses 2 and 3 change the latch, which reads back, and leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| cnt_pin | input | 1 | External count input, asynchronous |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong reload or timeout state shows up at the ports within one period. The counter read then breaks the L-n sequence at the 0xFFFF step, or the flag appears one cycle early or late against the L+2 spacing. The first flag after a restart exposes this, so the period is measured over several latch values, including 0 and 1. In pulse mode, a wrong synchroniser or edge detector changes the counter value read a few cycles after a single pin transition. A wrong arming state shows up as a flag that returns after the count wraps past zero.

// File: rtl/pulse_timer16.sv
module pulse_timer16 #(
  parameter int CW    = 16,
  parameter int TFLAG = 6,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cnt_pin,
  output logic       irq_n
);
  localparam int BW = CW / 2;

  logic [CW-1:0] cnt, latch;
  logic [SYNC:0] sync_q;
  logic mode, run, armed, pend, flag, ien;
  logic wr, wr_chi, rd_clo, fall, pulse_hit, hit, clr_req, step;

  assign wr        = cs & we;
  assign wr_chi    = wr & (addr == 3'd1);
  assign rd_clo    = cs & ~we & (addr == 3'd0);
  assign fall      = sync_q[SYNC] & ~sync_q[SYNC-1];
  assign step      = run & (mode ? fall : 1'b1);
  assign pulse_hit = run & mode & armed & fall & (cnt == CW'(1));
  assign hit       = pend | pulse_hit;
  assign clr_req   = wr_chi | rd_clo | (wr & (addr == 3'd5) & wdata[TFLAG]);
  assign irq_n     = ~(flag & ien);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-1:0], cnt_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latch <= '0;
      mode  <= 1'b0;
      ien   <= 1'b0;
    end else if (wr) begin
      case (addr)
        3'd0, 3'd2: latch[BW-1:0]  <= wdata;
        3'd1, 3'd3: latch[CW-1:BW] <= wdata;
        3'd4:       mode <= wdata[0];
        3'd6:       ien  <= wdata[TFLAG];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      pend  <= 1'b0;
      run   <= 1'b0;
      armed <= 1'b0;
    end else if (wr_chi) begin
      cnt   <= {wdata, latch[BW-1:0]};
      pend  <= 1'b0;
      run   <= 1'b1;
      armed <= 1'b1;
    end else begin
      if (pulse_hit) armed <= 1'b0;
      if (pend) begin
        cnt  <= latch;
        pend <= 1'b0;
      end else if (step) begin
        cnt  <= cnt - CW'(1);
        pend <= ~mode & (cnt == '0);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag <= 1'b0;
    else if (wr_chi)   flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (clr_req)  flag <= 1'b0;

  always_comb
    case (addr)
      3'd0:    rdata = cnt[BW-1:0];
      3'd1:    rdata = cnt[CW-1:BW];
      3'd2:    rdata = latch[BW-1:0];
      3'd3:    rdata = latch[CW-1:BW];
      3'd4:    rdata = {7'd0, mode};
      3'd5:    rdata = 8'(flag) << TFLAG;
      3'd6:    rdata = 8'(ien) << TFLAG;
      default: rdata = 8'd0;
    endcase
endmodule

module pulse_timer16_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_chi,
  input logic          pend,
  input logic          fall,
  input logic          mode,
  input logic          run,
  input logic          flag,
  input logic          hit,
  input logic          clr_req,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] latch,
  input logic [7:0]    wdata
);
  // R9
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chi |=> (cnt == {$past(wdata), $past(latch[CW/2-1:0])}) && !flag);
  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !wr_chi |=> (cnt == $past(latch)) && flag);
  // R4
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode && !fall && !wr_chi |=> $stable(cnt));
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !hit |=> !flag);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_req |=> flag);
endmodule

bind pulse_timer16 pulse_timer16_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_chi(wr_chi), .pend(pend), .fall(fall),
  .mode(mode), .run(run), .flag(flag), .hit(hit), .clr_req(clr_req),
  .cnt(cnt), .latch(latch), .wdata(wdata)
);

// File: tb/pulse_timer16_bench.sv
module pulse_timer16_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, we = 1'b0, cnt_pin = 1'b1;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq_n;
  int cyc = 0, checks = 0, fails = 0;

  localparam logic [15:0] LAT [4] = '{16'd10, 16'd0, 16'd1, 16'd300};
  localparam int          PER [4] = '{12, 2, 3, 302};

  pulse_timer16 u_pulse_timer16 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_pin(cnt_pin), .irq_n(irq_n)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    cs = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_clear();
    cs = 1'b1; we = 1'b0; addr = 3'd0;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic pin(input logic v);
    cnt_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic poll_flag(output int at);
    logic [7:0] d;
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      peek(3'd5, d);
      if (d[6]) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    logic [7:0] d;
    int w, f1, f2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(3'd0, d); check("R1 cnt lo", d, 0);
    peek(3'd1, d); check("R1 cnt hi", d, 0);
    peek(3'd5, d); check("R1 flag", d, 0);
    check("R1 irq_n", irq_n, 1);

    for (int k = 0; k < 4; k++) begin
      wr(3'd4, 8'd0);
      wr(3'd0, LAT[k][7:0]);
      wr(3'd1, LAT[k][15:8]);
      w = cyc;
      poll_flag(f1);
      check("R2 first period", f1 - w, PER[k]);
      wr(3'd5, 8'h40);
      poll_flag(f2);
      check("R2 repeat period", f2 - f1, PER[k]);
    end

    wr(3'd0, 8'd40);
    wr(3'd1, 8'd0);
    for (int n = 0; n <= 42; n++) begin
      peek(3'd0, d);
      if (n <= 40)      check("R3 count down", d, 40 - n);
      else if (n == 41) check("R3 wrap", d, 8'hFF);
      else              check("R3 reload", d, 40);
      @(negedge clk);
    end

    wr(3'd4, 8'd1);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd0);
    peek(3'd0, d); check("R9 load", d, 3);
    peek(3'd5, d); check("R9 flag clear", d, 0);
    pin(1'b0); peek(3'd0, d); check("R4 fall", d, 2);
    pin(1'b1); peek(3'd0, d); check("R4 rise ignored", d, 2);
    wr(3'd2, 8'h55);
    peek(3'd2, d); check("R11 latch lo", d, 8'h55);
    peek(3'd0, d); check("R11 cnt kept", d, 2);
    wr(3'd3, 8'h12);
    peek(3'd3, d); check("R11 latch hi", d, 8'h12);
    peek(3'd1, d); check("R11 cnt hi kept", d, 0);
    pin(1'b0); pin(1'b1);
    peek(3'd5, d); check("R5 not yet", d, 0);
    pin(1'b0); pin(1'b1);
    peek(3'd0, d); check("R5 zero", d, 0);
    peek(3'd5, d); check("R5 flag", d, 8'h40);
    check("R6 irq masked", irq_n, 1);
    wr(3'd5, 8'hBF);
    peek(3'd5, d); check("R7 zero mask keeps", d, 8'h40);
    wr(3'd6, 8'h40);
    check("R10 irq low", irq_n, 0);
    wr(3'd5, 8'h40);
    peek(3'd5, d); check("R7 mask clears", d, 0);
    check("R10 irq released", irq_n, 1);
    pin(1'b0); pin(1'b1);
    peek(3'd0, d); check("R5 wrap lo", d, 8'hFF);
    peek(3'd5, d); check("R5 no second flag", d, 0);

    wr(3'd3, 8'd0);
    wr(3'd0, 8'd2);
    wr(3'd1, 8'd0);
    pin(1'b0); pin(1'b1); pin(1'b0); pin(1'b1);
    check("R10 irq on timeout", irq_n, 0);
    rd_clear();
    peek(3'd5, d); check("R8 read clears", d, 0);
    check("R10 irq after read", irq_n, 1);

    wr(3'd1, 8'd0);
    pin(1'b0); pin(1'b1); pin(1'b0); pin(1'b1);
    peek(3'd5, d); check("R9 flag set before", d, 8'h40);
    wr(3'd1, 8'd0);
    peek(3'd5, d); check("R9 restart clears", d, 0);
    peek(3'd0, d); check("R9 reloaded", d, 2);
    done();
  end
endmodule